// File: doc/BRIEF.md
# Two-Stage PWM Clock Prescaler

This block derives a PWM time base from the operating clock through two cascaded divider stages. It then runs a 64-step PWM period from the slower rate that results. A 2-bit coarse field selects one of four modes: off, divide-by-1, divide-by-8 or divide-by-16. A 4-bit fine field then divides the coarse rate by its own value plus one. Both stages are clock enables on the operating clock, so the block contains no generated clocks.

An 8-bit control register with a write strobe holds both fields. Every write to it restarts the dividers and the period counter, so a new rate starts on a clean period boundary. A separate 6-bit duty register sets how many of the 64 steps drive the PWM output high. A nonzero coarse field makes the output pin carry the PWM waveform. While the coarse field is zero the block is off and the pin follows the general-purpose port value.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: After reset the control readback is 0x00, and `pwm_out`, `period_start` and `pin_override` are all low.
- R2: The control readback returns the coarse field in bits 5:4 and the fine field in bits 3:0. Bits 7:6 always read 0, whatever was written to them.
- R3: With coarse field 00 the block is off: `period_start` never pulses, `pwm_out` stays low and all counters are held at zero.
- R4: With coarse code 01, 10 or 11 (divide by 1, 8 or 16) and fine value F, successive `period_start` pulses are exactly 64 × coarse ratio × (F+1) operating-clock cycles apart. The range is 64 to 16384 cycles.
- R5: Different settings that give the same overall rate are both valid and give the same period. Coarse 10 with fine 0 and coarse 01 with fine 7 both give 512 cycles.
- R6: A nonzero coarse field drives `pin_override` high and makes `pin_out` equal `pwm_out`. Coarse 00 drives `pin_override` low and makes `pin_out` equal `port_val`.
- R7: `pwm_out` is high while the period step is below the duty value, giving duty × (period/64) high cycles per period. A duty of 0 keeps the output low, and a duty of 63 keeps it high for 63 of 64 steps.
- R8: A control write clears both prescaler counters and the period counter. The first `period_start` after the write comes exactly one full period after the write edge, even when the write lands in the middle of a period.
- R9: `period_start` is a single-cycle pulse issued once per period, in the last operating-clock cycle of step 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: coarse in 5:4, fine in 3:0 |
| ctrl_rdata | output | 8 | Control register readback |
| duty_wr | input | 1 | Duty register write strobe |
| duty_wdata | input | 6 | Duty value, 0 to 63 |
| port_val | input | 1 | General-purpose port value for the pin |
| period_start | output | 1 | One-cycle pulse at each period wrap |
| pwm_out | output | 1 | PWM waveform |
| pin_override | output | 1 | High when the pin carries the PWM output |
| pin_out | output | 1 | Value driven to the pin |

## Verification
The assertions check on every cycle that the block stays quiet while off and that a zero duty keeps the output low. They also check that a control write leaves the period counter at zero, that the coarse enable never fires two cycles in a row above divide-by-1, and that `period_start` is never two cycles wide. Only the bench's scenarios can show the exact period lengths for each coarse and fine pair, including the two equivalent 512-cycle settings. The same holds for the high-time count per duty value, the restart after a write in mid-period, and the pin selection between PWM and port value.

// File: rtl/pwmpre_pkg.sv
package pwmpre_pkg;

   typedef enum logic [1:0] {
      CS_OFF   = 2'b00,
      CS_DIV1  = 2'b01,
      CS_DIV8  = 2'b10,
      CS_DIV16 = 2'b11
   } coarse_e;

   // terminal count of the coarse counter for each mode (ratio - 1)
   function automatic logic [3:0] coarse_last(input coarse_e sel);
      case (sel)
         CS_DIV8:  coarse_last = 4'd7;
         CS_DIV16: coarse_last = 4'd15;
         default:  coarse_last = 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/pwmpre_coarse.sv
module pwmpre_coarse
   import pwmpre_pkg::*;
#(
   parameter int CRS_W = 4
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clr,
   input  coarse_e sel,
   output logic    cen
);
   generate
      if (CRS_W < 4) begin : g_bad_w
         $error("CRS_W must be at least 4 to reach divide-by-16");
      end
   endgenerate

   logic             on;
   logic [CRS_W-1:0] cnt;
   logic [CRS_W-1:0] last;

   assign on   = (sel != CS_OFF);
   assign last = CRS_W'(coarse_last(sel));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr || !on)    cnt <= '0;
      else if (cnt == last)   cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   assign cen = on && !clr && (cnt == last);

   AST_CEN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (cen && sel != CS_DIV1 && !clr) |=> !cen) else $error("coarse enable too dense"); // R4

endmodule

// File: rtl/pwmpre_fine.sv
module pwmpre_fine #(
   parameter int FINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              on,
   input  logic              cen,
   input  logic [FINE_W-1:0] fine,
   output logic              fen
);
   logic [FINE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr || !on)  cnt <= '0;
      else if (cen) begin
         if (cnt == fine)   cnt <= '0;
         else               cnt <= cnt + 1'b1;
      end
   end

   assign fen = cen && (cnt == fine);

   AST_FEN_NEEDS_CEN: assert property (@(posedge clk) disable iff (!rst_n)
      fen |-> on) else $error("fine enable while off"); // R3

endmodule

// File: rtl/pwmpre_period.sv
module pwmpre_period #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             on,
   input  logic             fen,
   input  logic [CNT_W-1:0] duty,
   output logic [CNT_W-1:0] step,
   output logic             period_start,
   output logic             pwm_out
);
   localparam logic [CNT_W-1:0] STEP_LAST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           step <= '0;
      else if (clr || !on)  step <= '0;
      else if (fen)         step <= step + 1'b1;
   end

   assign period_start = fen && (step == STEP_LAST);
   assign pwm_out      = on && (step < duty);

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !on |-> (!pwm_out && !period_start && step == '0)) else $error("activity while off"); // R3
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> !period_start) else $error("period_start wider than one cycle"); // R9
   AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (duty == '0) |-> !pwm_out) else $error("output high with zero duty"); // R7

endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler
   import pwmpre_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int FINE_W = 4,
   parameter int CRS_W  = 4,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   input  logic              duty_wr,
   input  logic [CNT_W-1:0]  duty_wdata,
   input  logic              port_val,
   output logic              period_start,
   output logic              pwm_out,
   output logic              pin_override,
   output logic              pin_out
);
   localparam int CRS_LO = FINE_W;
   localparam int CRS_HI = FINE_W + 1;

   generate
      if (CTRL_W < FINE_W + 2) begin : g_bad_ctrl
         $error("CTRL_W too small for coarse and fine fields");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
   endgenerate

   coarse_e           coarse_q;
   logic [FINE_W-1:0] fine_q;
   logic [CNT_W-1:0]  duty_q;
   logic              on;
   logic              cen;
   logic              fen;
   logic [CNT_W-1:0]  step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= CS_OFF;
         fine_q   <= '0;
      end else if (ctrl_wr) begin
         coarse_q <= coarse_e'(ctrl_wdata[CRS_HI:CRS_LO]);
         fine_q   <= ctrl_wdata[FINE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       duty_q <= '0;
      else if (duty_wr) duty_q <= duty_wdata;
   end

   always_comb begin
      ctrl_rdata               = '0;
      ctrl_rdata[CRS_HI:CRS_LO] = coarse_q;
      ctrl_rdata[FINE_W-1:0]   = fine_q;
   end

   assign on           = (coarse_q != CS_OFF);
   assign pin_override = on;
   assign pin_out      = on ? pwm_out : port_val;

   pwmpre_coarse #(.CRS_W(CRS_W)) u_coarse (
      .clk (clk),
      .rst_n (rst_n),
      .clr (ctrl_wr),
      .sel (coarse_q),
      .cen (cen)
   );

   pwmpre_fine #(.FINE_W(FINE_W)) u_fine (
      .clk (clk),
      .rst_n (rst_n),
      .clr (ctrl_wr),
      .on (on),
      .cen (cen),
      .fine (fine_q),
      .fen (fen)
   );

   pwmpre_period #(.CNT_W(CNT_W)) u_period (
      .clk (clk),
      .rst_n (rst_n),
      .clr (ctrl_wr),
      .on (on),
      .fen (fen),
      .duty (duty_q),
      .step (step),
      .period_start (period_start),
      .pwm_out (pwm_out)
   );

   AST_WR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (step == '0 && !period_start)) else $error("write did not restart period"); // R8
   AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_override |-> !pwm_out) else $error("pwm active without pin override"); // R6

endmodule

// File: tb/pwm_clk_prescaler_tb.sv
module pwm_clk_prescaler_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic [7:0] ctrl_rdata;
   logic       duty_wr = 1'b0;
   logic [5:0] duty_wdata = '0;
   logic       port_val = 1'b0;
   logic       period_start, pwm_out, pin_override, pin_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;   // 125 MHz

   pwm_clk_prescaler u_dut (
      .clk (clk), .rst_n (rst_n),
      .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata), .ctrl_rdata (ctrl_rdata),
      .duty_wr (duty_wr), .duty_wdata (duty_wdata),
      .port_val (port_val),
      .period_start (period_start), .pwm_out (pwm_out),
      .pin_override (pin_override), .pin_out (pin_out)
   );

   typedef struct packed {
      logic [1:0] crs;
      logic [3:0] fin;
      logic [15:0] per;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{crs: 2'b01, fin: 4'd0,  per: 16'd64},
      '{crs: 2'b01, fin: 4'd7,  per: 16'd512},
      '{crs: 2'b10, fin: 4'd0,  per: 16'd512},
      '{crs: 2'b11, fin: 4'd0,  per: 16'd1024},
      '{crs: 2'b10, fin: 4'd3,  per: 16'd2048},
      '{crs: 2'b11, fin: 4'd15, per: 16'd16384}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic wr_duty(input logic [5:0] v);
      @(negedge clk); duty_wr = 1'b1; duty_wdata = v;
      @(negedge clk); duty_wr = 1'b0;
   endtask

   // counts negedges from the current one until period_start is seen
   task automatic measure(output int n);
      n = 1;
      while (!period_start && n < 20000) begin
         @(negedge clk); n++;
      end
   endtask

   task automatic high_count(input int len, output int h, output int starts);
      h = 0; starts = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (pwm_out) h++;
         if (period_start) starts++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int n, h, s;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctrl_rdata == 8'h00, "R1 rdata", ctrl_rdata, 0);
      chk(!pwm_out && !period_start && !pin_override, "R1 outputs", {pwm_out, period_start, pin_override}, 0);
      rst_n = 1'b1;

      // vector table: R4 period lengths, R5 equivalent settings, R8 first period after write
      for (int i = 0; i < NVEC; i++) begin
         wr_ctrl({2'b00, VECS[i].crs, VECS[i].fin});
         measure(n);
         chk(n == int'(VECS[i].per), "R8 first period", n, VECS[i].per);
         @(negedge clk);
         measure(n);
         if (i == 1 || i == 2)
            chk(n == int'(VECS[i].per), "R5 equivalent rate", n, VECS[i].per);
         else
            chk(n == int'(VECS[i].per), "R4 period", n, VECS[i].per);
      end

      // R2 readback masks bits 7:6
      wr_ctrl(8'hFF);
      chk(ctrl_rdata == 8'h3F, "R2 readback", ctrl_rdata, 8'h3F);
      wr_ctrl(8'hE6);
      chk(ctrl_rdata == 8'h26, "R2 readback fields", ctrl_rdata, 8'h26);

      // R6 pin override when running
      chk(pin_override == 1'b1, "R6 override on", pin_override, 1);
      port_val = 1'b1;
      wr_duty(6'd0);
      @(negedge clk);
      chk(pin_out == pwm_out && pin_out == 1'b0, "R6 pin follows pwm", pin_out, 0);

      // R7 duty sweep at 64-cycle period
      wr_ctrl(8'h10);
      foreach (VECS[j]) begin end
      for (int d = 0; d < 4; d++) begin
         int dv;
         dv = (d == 0) ? 0 : (d == 1) ? 63 : (d == 2) ? 32 : 1;
         wr_duty(6'(dv));
         @(negedge clk);
         measure(n);
         high_count(64, h, s);
         chk(h == dv, "R7 high cycles", h, dv);
         chk(s == 1, "R9 one start per period", s, 1);
      end

      // R7 with slower rate: duty 10 at coarse 01 fine 3 -> 40 high cycles
      wr_duty(6'd10);
      wr_ctrl(8'h13);
      measure(n);
      high_count(256, h, s);
      chk(h == 40, "R7 scaled high time", h, 40);

      // R8 restart mid-period with same value
      measure(n);
      repeat (100) @(negedge clk);
      wr_ctrl(8'h13);
      measure(n);
      chk(n == 256, "R8 mid-period restart", n, 256);

      // R3 off: no pulses, low output; R6 pin follows port
      wr_ctrl(8'h05);
      high_count(300, h, s);
      chk(h == 0 && s == 0, "R3 off quiet", h + s, 0);
      chk(pin_override == 1'b0, "R6 override off", pin_override, 0);
      port_val = 1'b1; @(negedge clk);
      chk(pin_out == 1'b1, "R6 pin port high", pin_out, 1);
      port_val = 1'b0; @(negedge clk);
      chk(pin_out == 1'b0, "R6 pin port low", pin_out, 0);

      // R3 counters held: turning on gives a full first period
      repeat (37) @(negedge clk);
      wr_ctrl(8'h10);
      measure(n);
      chk(n == 64, "R3 counters held at zero", n, 64);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule